// File: doc/BRIEF.md
# Asynchronous HDLC Transmit Framer with Octet Stuffing

This block turns a stream of frame bytes into the character sequence of an asynchronous HDLC link in the PPP style. Frame bytes arrive on a valid/ready byte stream with a last-byte marker. Characters leave on a byte valid/ready interface toward a character serializer, which adds start and stop bits. Each frame goes out as an opening flag, then the stuffed payload, then a stuffed 16-bit FCS, then a closing flag. The link is never left without a character: idle characters fill the time between frames and any gap inside a frame where the source has no byte ready.

Transparency is decided per byte. A byte is replaced by the escape character followed by the byte XOR 0x20 when any of these hold: it equals the opening flag, it equals the closing flag, it equals the escape character, or it is below 0x20 and its bit is set in a 32-bit control map. The flag, escape and idle values are inputs, so firmware can program them. A one-cycle abort pulse during a frame ends that frame with the escape character followed by the closing flag, with no FCS. The block then drops the unsent part of the frame from the source. This framing applies only to asynchronous character links and does no bit-level stuffing.

Usual settings are 0x7E for both flags, 0x7D for escape and 0xFF for idle. The configuration inputs are expected to change only between frames.

Top module: `ahdlc_tx_framer`

## Requirements
- R1: While rst_ni is low, out_valid_o and in_ready_o are 0. The first character offered after reset is the idle character.
- R2: Every frame is sent as the opening flag, then the payload bytes in order, then two FCS characters, then the closing flag. Each frame has its own opening flag. No input byte is accepted before that frame's opening flag has been loaded.
- R3: A payload byte equal to open_flag_i, close_flag_i or esc_char_i is sent as esc_char_i followed by the byte XOR 0x20.
- R4: A payload byte with value n below 0x20 is escaped in the same way exactly when bit n of ctl_map_i is 1. Any other byte that matches neither flag nor the escape value is sent unchanged.
- R5: The FCS is CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF, computed over the payload. It is sent complemented, low byte first, and each FCS byte is stuffed like payload. For the payload "123456789" the FCS characters are 0x6E and then 0x90.
- R6: Once reset is released, out_valid_o stays 1. The idle character idle_char_i is sent between frames, and also inside a frame whenever in_valid_i is 0 at the moment the next character is chosen.
- R7: An abort_i pulse given after the opening flag and before the last FCS character has been loaded makes the block send esc_char_i and then close_flag_i instead of the rest of the frame, with no FCS. If the last payload byte has not yet been taken, the remaining input bytes up to and including the one marked last are accepted and discarded.
- R8: An abort_i pulse while no frame is in progress has no effect, and the next frame is sent normally.
- R9: While out_valid_o is 1 and out_ready_i is 0, out_char_o holds its value.
- R10: The flag, escape and idle values are taken from their inputs. With non-default values, a byte 0x7E is sent unchanged and bytes equal to the new values are escaped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| open_flag_i | input | 8 | Opening flag value |
| close_flag_i | input | 8 | Closing flag value |
| esc_char_i | input | 8 | Escape character value |
| idle_char_i | input | 8 | Idle fill character |
| ctl_map_i | input | 32 | Bit n set: escape byte value n (n < 32) |
| abort_i | input | 1 | One-cycle pulse that aborts the current frame |
| in_data_i | input | 8 | Frame byte |
| in_valid_i | input | 1 | Frame byte is valid |
| in_last_i | input | 1 | Frame byte is the last one of its frame |
| in_ready_o | output | 1 | Frame byte is taken this cycle |
| out_char_o | output | 8 | Character toward the serializer |
| out_valid_o | output | 1 | Character is valid |
| out_ready_i | input | 1 | Serializer takes the character |

## Verification
A frame of plain printable bytes with an all-zero control map shows that bytes needing no escape pass unchanged. A frame that mixes flag and escape values with control bytes whose map bits are set and others whose bits are clear shows which escaping rule is applied to which byte. The nine-digit check string separates a correct FCS polynomial, seed, complement and byte order from near-miss variants. Non-default flag, escape and idle values show that the block uses the programmed values and not fixed constants. Source gaps, a stalling serializer, back-to-back frames, an abort in the middle of a frame and an abort while idle exercise the idle fill, output holding, per-frame opening flags and the abort and drop path.

// File: rtl/ahdlc_pkg.sv
package ahdlc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DATA, S_FCS_LO, S_FCS_HI, S_CLOSE, S_ABORT, S_DROP
  } state_e;
endpackage

// File: rtl/ahdlc_esc_chk.sv
module ahdlc_esc_chk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned MAP_W = 32
) (
  input  logic [DW-1:0]    data_i,
  input  logic [MAP_W-1:0] map_i,
  input  logic [DW-1:0]    open_flag_i,
  input  logic [DW-1:0]    close_flag_i,
  input  logic [DW-1:0]    esc_char_i,
  output logic             need_o
);
  localparam int unsigned IDX_W = $clog2(MAP_W);

  logic ctl_hit, val_hit;
  assign ctl_hit = (data_i < DW'(MAP_W)) && map_i[data_i[IDX_W-1:0]];
  assign val_hit = (data_i == open_flag_i) || (data_i == close_flag_i) ||
                   (data_i == esc_char_i);
  assign need_o  = ctl_hit || val_hit;
endmodule

// File: rtl/ahdlc_fcs.sv
module ahdlc_fcs #(
  parameter int unsigned DW    = 8,
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8408,
  parameter logic [CRC_W-1:0] SEED = 16'hFFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [DW-1:0]    data_i,
  output logic [CRC_W-1:0] crc_o
);
  function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c,
                                           input logic [DW-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < int'(DW); i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= SEED;
    else if (clr_i)  crc_o <= SEED;
    else if (upd_i)  crc_o <= step(crc_o, data_i);
  end
endmodule

// File: rtl/ahdlc_tx_framer.sv
module ahdlc_tx_framer #(
  parameter int unsigned DW    = 8,
  parameter int unsigned MAP_W = 32,
  parameter logic [DW-1:0] ESC_XOR = 8'h20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    open_flag_i,
  input  logic [DW-1:0]    close_flag_i,
  input  logic [DW-1:0]    esc_char_i,
  input  logic [DW-1:0]    idle_char_i,
  input  logic [MAP_W-1:0] ctl_map_i,
  input  logic             abort_i,
  input  logic [DW-1:0]    in_data_i,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  output logic [DW-1:0]    out_char_o,
  output logic             out_valid_o,
  input  logic             out_ready_i
);
  import ahdlc_pkg::*;
  localparam int unsigned CRC_W = 2 * DW;

  state_e           state_q, state_d;
  logic             pend_v_q, pend_v_d;
  logic [DW-1:0]    pend_q, pend_d;
  logic [DW-1:0]    out_q, out_d;
  logic             out_v_q;
  logic             abort_q, abort_d;
  logic             drop_q, drop_d;
  logic             adv, take, crc_clr, need;
  logic [DW-1:0]    cand;
  logic [CRC_W-1:0] crc;

  assign adv  = !out_v_q || out_ready_i;
  assign cand = (state_q == S_DATA)   ? in_data_i :
                (state_q == S_FCS_LO) ? ~crc[DW-1:0] : ~crc[CRC_W-1:DW];

  ahdlc_esc_chk #(.DW(DW), .MAP_W(MAP_W)) u_esc (
    .data_i(cand), .map_i(ctl_map_i), .open_flag_i(open_flag_i),
    .close_flag_i(close_flag_i), .esc_char_i(esc_char_i), .need_o(need)
  );

  ahdlc_fcs #(.DW(DW), .CRC_W(CRC_W)) u_fcs (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(crc_clr), .upd_i(take),
    .data_i(in_data_i), .crc_o(crc)
  );

  always_comb begin
    state_d  = state_q;
    pend_v_d = pend_v_q;
    pend_d   = pend_q;
    out_d    = out_q;
    drop_d   = drop_q;
    take     = 1'b0;
    crc_clr  = 1'b0;
    abort_d  = abort_q;
    if (adv) begin
      if (pend_v_q) begin
        out_d    = pend_q;
        pend_v_d = 1'b0;
      end else begin
        unique case (state_q)
          S_IDLE: begin
            if (in_valid_i) begin
              out_d   = open_flag_i;
              state_d = S_DATA;
              crc_clr = 1'b1;
            end else out_d = idle_char_i;
          end
          S_DATA, S_FCS_LO, S_FCS_HI: begin
            if (abort_q) begin
              out_d   = esc_char_i;
              state_d = S_ABORT;
              drop_d  = (state_q == S_DATA);
              abort_d = 1'b0;
            end else if (state_q == S_DATA && !in_valid_i) begin
              out_d = idle_char_i;
            end else begin
              take = (state_q == S_DATA);
              if (need) begin
                out_d    = esc_char_i;
                pend_v_d = 1'b1;
                pend_d   = cand ^ ESC_XOR;
              end else out_d = cand;
              unique case (state_q)
                S_DATA:   state_d = in_last_i ? S_FCS_LO : S_DATA;
                S_FCS_LO: state_d = S_FCS_HI;
                default:  state_d = S_CLOSE;
              endcase
            end
          end
          S_CLOSE: begin
            out_d   = close_flag_i;
            state_d = S_IDLE;
          end
          S_ABORT: begin
            out_d   = close_flag_i;
            state_d = drop_q ? S_DROP : S_IDLE;
          end
          S_DROP:  out_d = idle_char_i;
          default: state_d = S_IDLE;
        endcase
      end
    end
    // discard the rest of an aborted frame regardless of the output side
    if (state_q == S_DROP && in_valid_i && in_last_i) state_d = S_IDLE;
    // abort is held only while the frame can still be cut short
    if (state_d == S_DATA || state_d == S_FCS_LO || state_d == S_FCS_HI)
      abort_d = abort_d || abort_i;
    else
      abort_d = 1'b0;
  end

  assign in_ready_o  = take || (state_q == S_DROP);
  assign out_char_o  = out_q;
  assign out_valid_o = out_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      pend_v_q <= 1'b0;
      pend_q   <= '0;
      out_q    <= '0;
      out_v_q  <= 1'b0;
      abort_q  <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      pend_v_q <= pend_v_d;
      pend_q   <= pend_d;
      abort_q  <= abort_d;
      drop_q   <= drop_d;
      if (adv) begin
        out_q   <= out_d;
        out_v_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ahdlc_tx_framer_chk.sv
module ahdlc_tx_framer_chk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned MAP_W = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input ahdlc_pkg::state_e    st_i,
  input logic [DW-1:0]        open_flag_i,
  input logic [DW-1:0]        close_flag_i,
  input logic [DW-1:0]        esc_char_i,
  input logic [MAP_W-1:0]     ctl_map_i,
  input logic [DW-1:0]        in_data_i,
  input logic                 in_valid_i,
  input logic                 in_ready_o,
  input logic [DW-1:0]        out_char_o,
  input logic                 out_valid_o,
  input logic                 out_ready_i
);
  import ahdlc_pkg::*;
  localparam int unsigned IDX_W = $clog2(MAP_W);

  logic took, val_hit, map_hit;
  assign took    = in_valid_i && in_ready_o && (st_i == S_DATA);
  assign val_hit = (in_data_i == open_flag_i) || (in_data_i == close_flag_i) ||
                   (in_data_i == esc_char_i);
  assign map_hit = (in_data_i < DW'(MAP_W)) && ctl_map_i[in_data_i[IDX_W-1:0]];

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_char_o)));

  p_valid_stays_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> out_valid_o);

  p_idle_no_take_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == S_IDLE) |-> !in_ready_o);

  p_flag_esc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (took && val_hit) |=> (out_char_o == esc_char_i));

  p_map_esc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (took && map_hit) |=> (out_char_o == esc_char_i));

  p_plain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (took && !map_hit && !val_hit) |=> (out_char_o == $past(in_data_i)));

  p_abort_esc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == S_ABORT) |-> (out_valid_o && out_char_o == esc_char_i));
endmodule

bind ahdlc_tx_framer ahdlc_tx_framer_chk #(.DW(DW), .MAP_W(MAP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st_i(state_q),
  .open_flag_i(open_flag_i), .close_flag_i(close_flag_i),
  .esc_char_i(esc_char_i), .ctl_map_i(ctl_map_i),
  .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .out_char_o(out_char_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i)
);

// File: tb/ahdlc_tx_framer_bench.sv
module ahdlc_tx_framer_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] ch;
    string      tag;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  open_flag = 8'h7E, close_flag = 8'h7E, esc_char = 8'h7D;
  logic [7:0]  idle_char = 8'hFF, idle_old = 8'hFF;
  logic [31:0] ctl_map = 32'h0;
  logic        abort = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic        in_ready, out_valid, out_ready = 1'b1;
  logic [7:0]  out_char;
  int          rdy_mode = 0;
  int          n_cmp = 0, n_bad = 0, idle_skips = 0;
  bit          done = 1'b0;
  exp_t        exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ahdlc_tx_framer u_ahdlc_tx_framer (
    .clk_i(clk), .rst_ni(rst_n), .open_flag_i(open_flag),
    .close_flag_i(close_flag), .esc_char_i(esc_char), .idle_char_i(idle_char),
    .ctl_map_i(ctl_map), .abort_i(abort), .in_data_i(in_data),
    .in_valid_i(in_valid), .in_last_i(in_last), .in_ready_o(in_ready),
    .out_char_o(out_char), .out_valid_o(out_valid), .out_ready_i(out_ready)
  );

  always @(posedge clk) out_ready <= (rdy_mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && !done) begin
      if (exp_q.size() == 0) begin
        if (out_char != idle_char && out_char != idle_old)
          check(1'b0, "R6 idle between frames", out_char, idle_char);
      end else if ((out_char == idle_char || out_char == idle_old) &&
                   exp_q[0].ch != out_char) begin
        idle_skips++;
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(out_char == e.ch, e.tag, out_char, e.ch);
      end
    end
  end

  function automatic bit needs_esc(input logic [7:0] b);
    return (b == open_flag) || (b == close_flag) || (b == esc_char) ||
           (b < 8'h20 && ctl_map[b[4:0]]);
  endfunction

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic push(input logic [7:0] ch, input string tag);
    exp_t e;
    e.ch = ch;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_stuffed(input logic [7:0] b, input string tag);
    if (needs_esc(b)) begin
      push(esc_char, {tag, " R3/R4 escape"});
      push(b ^ 8'h20, {tag, " R3/R4 escaped byte"});
    end else push(b, {tag, " R4 plain byte"});
  endtask

  task automatic drive_byte(input logic [7:0] b, input bit last, input int gap);
    in_data  = b;
    in_last  = last;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_last  = 1'b0;
    for (int g = 0; g < gap; g++) begin @(posedge clk); #1; end
  endtask

  task automatic send_frame(input logic [7:0] bytes[$], input int gap,
                            input bit fixed, input logic [15:0] fixed_fcs);
    logic [15:0] c, f;
    c = 16'hFFFF;
    push(open_flag, "R2 opening flag");
    foreach (bytes[i]) begin
      push_stuffed(bytes[i], "R2 payload");
      c = crc_byte(c, bytes[i]);
    end
    f = fixed ? fixed_fcs : ~c;
    push_stuffed(f[7:0], "R5 fcs low");
    push_stuffed(f[15:8], "R5 fcs high");
    push(close_flag, "R2 closing flag");
    foreach (bytes[i]) drive_byte(bytes[i], i == bytes.size() - 1, gap);
  endtask

  task automatic drain;
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 5000) begin @(posedge clk); t++; end
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired, queue=%0d expected=0", exp_q.size());
    finish_run();
  end

  initial begin
    logic [7:0] fr[$];
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready == 1'b0, "R1 in_ready in reset", in_ready, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    do @(negedge clk); while (!out_valid);
    check(out_char == 8'hFF, "R1 first char idle", out_char, 8'hFF);
    @(posedge clk); #1;

    // plain bytes, empty map
    fr = '{8'h41, 8'h42, 8'h20, 8'h7F, 8'hFF, 8'h80};
    send_frame(fr, 0, 1'b0, 16'h0);
    drain();

    // mixed escapes: map bits 0, 17, 19
    ctl_map = 32'h000A_0001;
    fr = '{8'h00, 8'h01, 8'h11, 8'h12, 8'h13, 8'h7E, 8'h7D, 8'h20, 8'h5A};
    send_frame(fr, 0, 1'b0, 16'h0);
    drain();

    // R5 known check vector
    ctl_map = 32'h0;
    fr = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    send_frame(fr, 0, 1'b1, 16'h906E);
    drain();

    // R9 stalling serializer, longer frame, full map
    ctl_map = 32'hFFFF_FFFF;
    rdy_mode = 1;
    fr = {};
    for (int i = 0; i < 24; i++) fr.push_back(8'(i * 13 + 3));
    send_frame(fr, 0, 1'b0, 16'h0);
    // R2 back-to-back frames, each with its own opening flag
    fr = '{8'h7E, 8'h03, 8'h44};
    send_frame(fr, 0, 1'b0, 16'h0);
    fr = '{8'h55};
    send_frame(fr, 0, 1'b0, 16'h0);
    drain();
    rdy_mode = 0;
    repeat (3) @(posedge clk); #1;

    // R10 programmed values
    ctl_map = 32'h0;
    open_flag = 8'hC0; close_flag = 8'hC1; esc_char = 8'hDB;
    idle_old = idle_char; idle_char = 8'hAA;
    repeat (4) @(posedge clk); #1;
    fr = '{8'h7E, 8'hC0, 8'hC1, 8'hDB, 8'h7D, 8'h33};
    send_frame(fr, 0, 1'b0, 16'h0);
    drain();
    open_flag = 8'h7E; close_flag = 8'h7E; esc_char = 8'h7D;
    idle_old = idle_char; idle_char = 8'hFF;
    repeat (4) @(posedge clk); #1;
    idle_old = 8'hFF;

    // R6 idle inside a frame when the source pauses
    idle_skips = 0;
    fr = '{8'h10, 8'h21, 8'h32, 8'h43, 8'h7E, 8'h65};
    send_frame(fr, 3, 1'b0, 16'h0);
    drain();
    check(idle_skips > 0, "R6 idle inside frame", idle_skips, 1);

    // R7 abort mid-frame, then drop of the rest
    push(open_flag, "R7 opening flag");
    push_stuffed(8'h51, "R7 partial");
    push_stuffed(8'h7E, "R7 partial");
    push_stuffed(8'h52, "R7 partial");
    drive_byte(8'h51, 1'b0, 0);
    drive_byte(8'h7E, 1'b0, 0);
    drive_byte(8'h52, 1'b0, 0);
    repeat (10) @(posedge clk); #1;
    push(esc_char, "R7 abort escape");
    push(close_flag, "R7 abort closing flag");
    abort = 1'b1;
    @(posedge clk); #1 abort = 1'b0;
    repeat (5) @(posedge clk); #1;
    drive_byte(8'h53, 1'b0, 0);
    drive_byte(8'h54, 1'b1, 0);
    drain();
    check(exp_q.size() == 0, "R7 abort sequence complete", exp_q.size(), 0);
    fr = '{8'h61, 8'h62};
    send_frame(fr, 0, 1'b0, 16'h0);
    drain();

    // R8 abort while idle is ignored
    abort = 1'b1;
    @(posedge clk); #1 abort = 1'b0;
    repeat (4) @(posedge clk); #1;
    fr = '{8'h71, 8'h05, 8'h72};
    send_frame(fr, 0, 1'b0, 16'h0);
    drain();
    check(exp_q.size() == 0, "R8 frame after idle abort", exp_q.size(), 0);
    check(out_valid == 1'b1, "R6 valid held after frames", out_valid, 1);

    finish_run();
  end
endmodule